// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a set of interrupt request lines from peripherals and routes them to several processor harts. Every source passes through its own gateway. The gateway turns the line into a single pending flag, and it can capture either a held level or a rising edge. Each source also carries a programmable priority. Each hart, called a target here, has its own enable mask and priority threshold. From these the target forms one external-interrupt line that goes high while any enabled, pending source is ranked above the threshold.

Software reaches the block through a plain word-wide register port. Reading a target's claim word hands out the best waiting source ID to that target and takes that source out of circulation. Writing the same ID back later frees the source. Each target also has a software-interrupt flag that software sets and clears directly. Read data appears one cycle after the access.

Top module: `irq_plic`

## Requirements
- R1: After reset every output is low, every pending flag is clear, and a claim read returns 0.
- R2: A source in level mode (mode bit 0) that is not claimed and whose line is high sets its pending flag at the next clock edge. The pending word holds source ID n at bit n, and bit 0 always reads 0.
- R3: A source in edge mode (mode bit 1) becomes pending only on a rising edge of its line. One rising edge seen while the source is claimed is kept and turns into a pending flag when the completion arrives. Several such edges still give only one. A line that simply stays high adds nothing.
- R4: extIrq[t] is high exactly when some source is pending, enabled for target t, and has a priority strictly above target t's threshold. A source with priority 0 never drives it.
- R5: A read of target t's claim word returns the ID of the eligible source with the highest priority. A tie goes to the lowest ID. The read returns 0 when no source is eligible.
- R6: A claim that returns a nonzero ID clears that source's pending flag, and the source takes no new request until the matching completion is written. After that completion, a level source whose line is still high becomes pending again.
- R7: A completion write has no effect when its ID is not currently claimed by the writing target, including an ID claimed by a different target.
- R8: Writing 1 to bit 0 of target t's software word drives swIrq[t] high from the next cycle, and writing 0 drives it low. The word reads back the same bit.
- R9: The pending word is read-only. Writes to it change nothing.
- R10: Register map for the default parameters (byte addresses, word aligned, read data one cycle after the read): pending word 0x000; mode word 0x004; priority of source n at 0x008+4n (bits 2:0); target t's block at 0x100*(t+1), holding the enable mask (bit n = source n) at +0x0, the threshold at +0x4, claim/complete at +0x8 (ID in bits 3:0) and the software bit at +0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | NumSrc | Request lines; bit n-1 belongs to source ID n |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | AddrW | Byte address of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| extIrq | output | NumTarget | External-interrupt line per target |
| swIrq | output | NumTarget | Software-interrupt line per target |

## Verification
A claim read and a fresh rising edge on the same edge-mode source can land on one clock edge. The claim clears the pending flag at the same moment the new edge would have set it. The bench raises the line in the very cycle it issues the claim read. It then checks that the read returns that source, that nothing is pending until completion, and that after completion the source is pending again and can be claimed exactly once more.

// File: rtl/irq_plic_pkg.sv
package irq_plic_pkg;
  localparam int TgtFieldW = 8;
  localparam int IdxFieldW = 16;

  typedef enum logic [2:0] {
    RK_NONE, RK_PEND, RK_MODE, RK_PRIO, RK_EN, RK_THR, RK_CC, RK_SW
  } regKind_e;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    regKind_e             kind;
    logic [TgtFieldW-1:0] tgt;
    logic [IdxFieldW-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/irq_plic_regctl.sv
module irq_plic_regctl
  import irq_plic_pkg::*;
#(
  parameter int NumSrc    = 12,
  parameter int NumTarget = 2,
  parameter int AddrW     = 12
) (
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [AddrW-1:0] regAddr,
  output regStrobe_t       strobe
);
  localparam int Words    = (NumSrc + 32) / 32;
  localparam int ModeBase = 4 * Words;
  localparam int PrioBase = 8 * Words;
  localparam int PrioEnd  = PrioBase + 4 * (NumSrc + 1);
  localparam int TgtBase  = ((PrioEnd + 255) / 256) * 256;
  localparam int TgtEnd   = TgtBase + 256 * NumTarget;

  logic [31:0] addr, off, lo;
  logic        unusedBits;
  assign unusedBits = ^regAddr[1:0];

  always_comb begin
    addr = '0;
    addr[AddrW-1:0] = regAddr;
    addr[1:0] = 2'b00;
    off = addr - 32'(TgtBase);
    lo  = {24'd0, off[7:0]};
    strobe = '0;
    strobe.kind = RK_NONE;
    if (regValid) begin
      strobe.wr = regWrite;
      strobe.rd = !regWrite;
      if (addr < 32'(ModeBase)) begin
        strobe.kind = RK_PEND;
        strobe.idx  = IdxFieldW'(addr >> 2);
      end else if (addr < 32'(PrioBase)) begin
        strobe.kind = RK_MODE;
        strobe.idx  = IdxFieldW'((addr - 32'(ModeBase)) >> 2);
      end else if (addr < 32'(PrioEnd)) begin
        strobe.kind = RK_PRIO;
        strobe.idx  = IdxFieldW'((addr - 32'(PrioBase)) >> 2);
      end else if (addr >= 32'(TgtBase) && addr < 32'(TgtEnd)) begin
        strobe.tgt = TgtFieldW'(off >> 8);
        if (lo < 32'(ModeBase)) begin
          strobe.kind = RK_EN;
          strobe.idx  = IdxFieldW'(lo >> 2);
        end else if (lo == 32'(ModeBase)) begin
          strobe.kind = RK_THR;
        end else if (lo == 32'(ModeBase + 4)) begin
          strobe.kind = RK_CC;
        end else if (lo == 32'(ModeBase + 8)) begin
          strobe.kind = RK_SW;
        end
      end
    end
  end
endmodule

// File: rtl/irq_plic_gateway.sv
module irq_plic_gateway (
  input  logic clk,
  input  logic rstN,
  input  logic srcLine,
  input  logic edgeMode,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic busy
);
  logic prevLine, latched, rise, request;

  assign rise    = srcLine & ~prevLine;
  assign request = edgeMode ? rise : srcLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine <= 1'b0;
      pending  <= 1'b0;
      busy     <= 1'b0;
      latched  <= 1'b0;
    end else begin
      prevLine <= srcLine;
      if (claim) begin
        pending <= 1'b0;
        busy    <= 1'b1;
        latched <= edgeMode & rise;
      end else if (complete) begin
        busy    <= 1'b0;
        latched <= 1'b0;
        if (edgeMode ? (latched | rise) : srcLine) pending <= 1'b1;
      end else if (busy) begin
        if (edgeMode & rise) latched <= 1'b1;
      end else if (request) begin
        pending <= 1'b1;
      end
    end
  end

  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    claim |=> (!pending && busy)); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !complete) |=> !pending); // R6
  AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeMode && srcLine && !busy && !claim && !complete) |=> pending); // R2
endmodule

// File: rtl/irq_plic_target.sv
module irq_plic_target #(
  parameter int NumSrc = 12,
  parameter int PrioW  = 3,
  parameter int IdW    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NumSrc:0]             pendVec,
  input  logic [NumSrc:0]             enVec,
  input  logic [(NumSrc+1)*PrioW-1:0] prioFlat,
  input  logic [PrioW-1:0]            thresh,
  output logic [IdW-1:0]              bestId,
  output logic                        irq
);
  logic [PrioW-1:0] bestPrio;

  always_comb begin
    bestId   = '0;
    bestPrio = thresh;
    for (int id = 1; id <= NumSrc; id++) begin
      if (pendVec[id] && enVec[id] && prioFlat[id*PrioW +: PrioW] > bestPrio) begin
        bestId   = IdW'(id);
        bestPrio = prioFlat[id*PrioW +: PrioW];
      end
    end
  end

  assign irq = (bestId != '0);

  AST_BEST_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pendVec[bestId] && enVec[bestId]
             && prioFlat[int'(bestId)*PrioW +: PrioW] > thresh)); // R4
endmodule

// File: rtl/irq_plic_datapath.sv
module irq_plic_datapath
  import irq_plic_pkg::*;
#(
  parameter int NumSrc    = 12,
  parameter int NumTarget = 2,
  parameter int PrioW     = 3,
  parameter int IdW       = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumSrc-1:0]    irqLines,
  input  regStrobe_t           strobe,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NumTarget-1:0] extIrq,
  output logic [NumTarget-1:0] swIrq
);
  localparam int TgtW = (NumTarget > 1) ? $clog2(NumTarget) : 1;

  logic [NumSrc:0]                  modeBits, pendVec, busyVec, claimVec, completeVec;
  logic [(NumSrc+1)*PrioW-1:0]      prioFlat;
  logic [NumTarget-1:0][NumSrc:0]   enBits;
  logic [NumTarget-1:0][PrioW-1:0]  thrR;
  logic [NumSrc:0][TgtW-1:0]        ownerR;
  logic [NumTarget-1:0][IdW-1:0]    bestIds;
  logic [TgtW-1:0]                  tIdx;
  logic [IdW-1:0]                   claimId, wid;
  logic                             isClaim, isCcWrite, widOk, isComplete;
  logic [31:0]                      readVal;
  int                               sIdx;
  logic                             unusedBits;

  assign unusedBits = ^{strobe.tgt, wdata};
  assign tIdx      = strobe.tgt[TgtW-1:0];
  assign sIdx      = int'(strobe.idx);
  assign claimId   = bestIds[tIdx];
  assign wid       = wdata[IdW-1:0];
  assign isClaim   = strobe.rd && strobe.kind == RK_CC && claimId != '0;
  assign isCcWrite = strobe.wr && strobe.kind == RK_CC;
  assign widOk     = (wdata != 32'd0) && (wdata < 32'(NumSrc + 1));
  assign isComplete = isCcWrite && widOk && busyVec[wid] && ownerR[wid] == tIdx;

  always_comb begin
    claimVec    = '0;
    completeVec = '0;
    for (int id = 1; id <= NumSrc; id++) begin
      claimVec[id]    = isClaim && int'(claimId) == id;
      completeVec[id] = isComplete && int'(wid) == id;
    end
  end

  assign pendVec[0] = 1'b0;
  assign busyVec[0] = 1'b0;

  for (genvar g = 1; g <= NumSrc; g++) begin : gSrc
    irq_plic_gateway uGate (
      .clk      (clk),
      .rstN     (rstN),
      .srcLine  (irqLines[g-1]),
      .edgeMode (modeBits[g]),
      .claim    (claimVec[g]),
      .complete (completeVec[g]),
      .pending  (pendVec[g]),
      .busy     (busyVec[g])
    );
    AST_FOREIGN_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
      (isCcWrite && int'(wid) == g && busyVec[g] && ownerR[g] != tIdx)
      |=> busyVec[g]); // R7
  end

  for (genvar t = 0; t < NumTarget; t++) begin : gTgt
    irq_plic_target #(.NumSrc(NumSrc), .PrioW(PrioW), .IdW(IdW)) uTgt (
      .clk      (clk),
      .rstN     (rstN),
      .pendVec  (pendVec),
      .enVec    (enBits[t]),
      .prioFlat (prioFlat),
      .thresh   (thrR[t]),
      .bestId   (bestIds[t]),
      .irq      (extIrq[t])
    );
    AST_SW_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wr && strobe.kind == RK_SW && int'(tIdx) == t)
      |=> swIrq[t] == $past(wdata[0])); // R8
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= '0;
      prioFlat <= '0;
      enBits   <= '0;
      thrR     <= '0;
      swIrq    <= '0;
      ownerR   <= '0;
    end else begin
      if (strobe.wr) begin
        for (int id = 1; id <= NumSrc; id++) begin
          if (strobe.kind == RK_MODE && id / 32 == sIdx) modeBits[id] <= wdata[id % 32];
          if (strobe.kind == RK_EN && id / 32 == sIdx) enBits[tIdx][id] <= wdata[id % 32];
          if (strobe.kind == RK_PRIO && id == sIdx) prioFlat[id*PrioW +: PrioW] <= wdata[PrioW-1:0];
        end
        if (strobe.kind == RK_THR) thrR[tIdx] <= wdata[PrioW-1:0];
        if (strobe.kind == RK_SW) swIrq[tIdx] <= wdata[0];
      end
      if (isClaim) ownerR[claimId] <= tIdx;
    end
  end

  always_comb begin
    readVal = '0;
    unique case (strobe.kind)
      RK_PEND: for (int id = 1; id <= NumSrc; id++)
                 if (id / 32 == sIdx) readVal[id % 32] = pendVec[id];
      RK_MODE: for (int id = 1; id <= NumSrc; id++)
                 if (id / 32 == sIdx) readVal[id % 32] = modeBits[id];
      RK_EN:   for (int id = 1; id <= NumSrc; id++)
                 if (id / 32 == sIdx) readVal[id % 32] = enBits[tIdx][id];
      RK_PRIO: for (int id = 1; id <= NumSrc; id++)
                 if (id == sIdx) readVal[PrioW-1:0] = prioFlat[id*PrioW +: PrioW];
      RK_THR:  readVal[PrioW-1:0] = thrR[tIdx];
      RK_CC:   readVal[IdW-1:0] = claimId;
      RK_SW:   readVal[0] = swIrq[tIdx];
      default: readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (strobe.rd) rdata <= readVal;
  end
endmodule

// File: rtl/irq_plic.sv
module irq_plic
  import irq_plic_pkg::*;
#(
  parameter int NumSrc    = 12,
  parameter int NumTarget = 2,
  parameter int MaxPrio   = 7,
  parameter int AddrW     = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumSrc-1:0]    irqLines,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [AddrW-1:0]     regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic [NumTarget-1:0] extIrq,
  output logic [NumTarget-1:0] swIrq
);
  localparam int PrioW = $clog2(MaxPrio + 1);
  localparam int IdW   = $clog2(NumSrc + 1);

  regStrobe_t strobe;

  irq_plic_regctl #(.NumSrc(NumSrc), .NumTarget(NumTarget), .AddrW(AddrW)) uCtl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  irq_plic_datapath #(.NumSrc(NumSrc), .NumTarget(NumTarget), .PrioW(PrioW), .IdW(IdW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .strobe   (strobe),
    .wdata    (regWdata),
    .rdata    (regRdata),
    .extIrq   (extIrq),
    .swIrq    (swIrq)
  );
endmodule

// File: tb/irq_plic_test.sv
module irq_plic_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] irqLines = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  extIrq, swIrq;
  int checks = 0, failures = 0;
  logic [31:0] rd;

  localparam logic [11:0] PEND = 12'h000, MODE = 12'h004;

  irq_plic uut (.clk(clk), .rstN(rstN), .irqLines(irqLines), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .extIrq(extIrq), .swIrq(swIrq));

  always #10 clk = ~clk;

  function automatic logic [11:0] prioA(int id); return 12'(8 + 4 * id); endfunction
  function automatic logic [11:0] enA(int t);   return 12'(256 * (t + 1)); endfunction
  function automatic logic [11:0] thrA(int t);  return 12'(256 * (t + 1) + 4); endfunction
  function automatic logic [11:0] ccA(int t);   return 12'(256 * (t + 1) + 8); endfunction
  function automatic logic [11:0] swA(int t);   return 12'(256 * (t + 1) + 12); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  task automatic setLine(input int id, input logic v);
    @(negedge clk);
    irqLines[id-1] = v;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 extIrq", 32'(extIrq), 0);
    check("R1 swIrq", 32'(swIrq), 0);
    busRead(PEND, rd); check("R1 pend", rd, 0);
    busRead(ccA(0), rd); check("R1 claim", rd, 0);
  endtask

  task automatic testLevel();
    busWrite(prioA(3), 2);
    busWrite(enA(0), 32'h8);
    setLine(3, 1); settle();
    busRead(PEND, rd); check("R2 level pend", rd, 32'h8);
    check("R4 routed t0 only", 32'(extIrq), 32'h1);
    busRead(ccA(0), rd); check("R5 claim id3", rd, 3);
    busRead(PEND, rd); check("R6 pend cleared", rd, 0);
    check("R6 irq dropped", 32'(extIrq), 0);
    busWrite(ccA(1), 3);
    busRead(PEND, rd); check("R7 foreign complete", rd, 0);
    busWrite(ccA(0), 7);
    busRead(PEND, rd); check("R7 unclaimed id", rd, 0);
    busWrite(ccA(0), 3);
    busRead(PEND, rd); check("R6 repend after complete", rd, 32'h8);
    setLine(3, 0);
    busRead(ccA(0), rd); check("R6 held pending", rd, 3);
    busWrite(ccA(0), 3);
    busRead(ccA(0), rd); check("R5 none left", rd, 0);
    busWrite(enA(0), 0);
  endtask

  task automatic testPriority();
    busWrite(prioA(1), 3); busWrite(prioA(2), 3); busWrite(prioA(5), 5);
    busWrite(enA(0), 32'h26); busWrite(thrA(0), 3);
    setLine(1, 1); setLine(2, 1); setLine(5, 1); settle();
    busRead(ccA(0), rd); check("R5 highest prio", rd, 5);
    check("R4 strict threshold", 32'(extIrq), 0);
    setLine(5, 0);
    busWrite(ccA(0), 5);
    busWrite(thrA(0), 2);
    check("R4 above threshold", 32'(extIrq), 1);
    busRead(ccA(0), rd); check("R5 tie lowest id", rd, 1);
    busRead(ccA(0), rd); check("R5 next tie", rd, 2);
    setLine(1, 0); setLine(2, 0);
    busWrite(ccA(0), 1); busWrite(ccA(0), 2);
    busRead(ccA(0), rd); check("R5 empty", rd, 0);
    busWrite(enA(0), 32'h10); busWrite(thrA(0), 0);
    setLine(4, 1); settle();
    busRead(PEND, rd); check("R4 prio0 pending", rd, 32'h10);
    check("R4 prio0 silent", 32'(extIrq), 0);
    busRead(ccA(0), rd); check("R5 prio0 not claimed", rd, 0);
    setLine(4, 0);
    busWrite(enA(0), 0);
  endtask

  task automatic testEdge();
    busWrite(MODE, 32'h40);
    busWrite(prioA(6), 1); busWrite(enA(1), 32'h40); busWrite(thrA(1), 0);
    setLine(6, 1); settle();
    check("R3 edge raises t1", 32'(extIrq), 32'h2);
    busRead(ccA(1), rd); check("R3 claim edge", rd, 6);
    busWrite(ccA(1), 6);
    busRead(ccA(1), rd); check("R3 held high no repend", rd, 0);
    setLine(6, 0); setLine(6, 1); settle();
    busRead(ccA(1), rd); check("R3 new edge", rd, 6);
    setLine(6, 0); setLine(6, 1); setLine(6, 0); setLine(6, 1); settle();
    check("R3 busy no irq", 32'(extIrq), 0);
    busWrite(ccA(1), 6);
    busRead(ccA(1), rd); check("R3 remembered edge", rd, 6);
    busWrite(ccA(1), 6);
    busRead(ccA(1), rd); check("R3 only one kept", rd, 0);
  endtask

  task automatic testSameCycle();
    setLine(6, 0); setLine(6, 1); settle();
    setLine(6, 0); settle();
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = ccA(1); irqLines[5] = 1'b1;
    @(negedge clk);
    regValid = 1'b0;
    check("R6 claim with edge", regRdata, 6);
    check("R6 blocked while claimed", 32'(extIrq), 0);
    busWrite(ccA(1), 6);
    check("R3 edge at claim kept", 32'(extIrq), 32'h2);
    busRead(ccA(1), rd); check("R3 reclaim", rd, 6);
    busWrite(ccA(1), 6);
    busRead(ccA(1), rd); check("R3 drained", rd, 0);
  endtask

  task automatic testSoftware();
    busWrite(swA(1), 1); check("R8 sw t1 set", 32'(swIrq), 32'h2);
    busRead(swA(1), rd); check("R8 sw readback", rd, 1);
    busWrite(swA(0), 1); check("R8 sw both", 32'(swIrq), 32'h3);
    busWrite(swA(1), 0); check("R8 sw t1 clear", 32'(swIrq), 32'h1);
    busWrite(swA(0), 0); check("R8 sw cleared", 32'(swIrq), 0);
  endtask

  task automatic testMap();
    busWrite(PEND, 32'hFFFF_FFFF);
    busRead(PEND, rd); check("R9 pend read-only", rd, 32'h10);
    check("R9 no irq from write", 32'(extIrq), 0);
    busRead(prioA(5), rd); check("R10 prio readback", rd, 5);
    busRead(MODE, rd); check("R10 mode readback", rd, 32'h40);
    busRead(enA(1), rd); check("R10 enable readback", rd, 32'h40);
    busWrite(thrA(1), 6);
    busRead(thrA(1), rd); check("R10 thr readback", rd, 6);
  endtask

  initial begin
    #(20 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLevel();
    testPriority();
    testEdge();
    testSameCycle();
    testSoftware();
    testMap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule